// File: doc/BRIEF.md
# Wishbone to Control-Register Bus Bridge

This block is a Wishbone classic slave that turns bus cycles into accesses on a bare control/status register bus. That bus has four signals: an address, a write strobe, write data and read data. It has no handshake, so the register side can never stall. The bridge and every register behind it share one system clock.

The Wishbone side carries word addresses, so the byte-offset bits have already been dropped. The top `SEG_W` bits of the word address pick the register segment: an access is claimed only when they equal `SEG_BASE`. The low `CSR_AW` bits become the register-bus address. Any bits between those two fields are ignored, so those addresses alias.

A write forwards its address and data and finishes in a single cycle. A read takes two cycles. In the first, the address goes onto the register bus. In the second, the bridge samples the data that the register side returns and hands it to the master.

Top module: `wb2csr_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `wb_ack` and `csr_we` are 0 and `csr_adr` and `csr_dat_w` are 0.
- R2: A claimed write (`wb_we`=1) has these effects in the cycle after the edge that samples it. `csr_we` is 1 for exactly that one cycle. `csr_adr` holds the low `CSR_AW` bits of `wb_adr`, and `csr_dat_w` holds `wb_dat_w`.
- R3: Every claimed transaction raises `wb_ack` for exactly one cycle. For a write, that is the same cycle in which `csr_we` is 1.
- R4: A claimed read (`wb_we`=0) puts its address on `csr_adr` in the cycle after it is sampled, with `csr_we` at 0 and `wb_ack` at 0. `wb_ack` rises in the following cycle.
- R5: In the read acknowledge cycle, `wb_dat_r` equals `csr_dat_r` as returned by the register side for that address. In every cycle without a read acknowledge, `wb_dat_r` is 0.
- R6: The bridge claims an access only when `wb_adr[ADDR_W-1 -: SEG_W]` equals `SEG_BASE`. When they differ, `wb_ack` and `csr_we` stay 0 and `csr_adr` keeps its value.
- R7: Word-address bits between the register field and the segment field are ignored. Two addresses that differ only in those bits reach the same register.
- R8: A request is taken only when `wb_cyc` and `wb_stb` are both 1. A new request is not sampled until the previous acknowledge has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | ADDR_W | Wishbone word address |
| wb_dat_w | input | DATA_W | Wishbone write data |
| wb_dat_r | output | DATA_W | Wishbone read data |
| wb_ack | output | 1 | Wishbone acknowledge |
| csr_adr | output | CSR_AW | Register-bus address |
| csr_we | output | 1 | Register-bus write strobe |
| csr_dat_w | output | DATA_W | Register-bus write data |
| csr_dat_r | input | DATA_W | Register-bus read data |

## Verification
The bench builds the bridge with a 30-bit word address, a segment field of 8 bits at base 0xE0, and a register field of only 14 bits. These values leave eight ignored middle bits, which makes the address aliasing of R7 observable; with the default widths there are no such bits. The register side is a small registered memory in the bench, so reads go through the real one-cycle turnaround of R4. The bench also drives addresses outside the segment and strobes without a cycle, to reach the cases where nothing must happen.

// File: rtl/wb2csr_pkg.sv
package wb2csr_pkg;

    // Bridge sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WACK = 2'd1,
        ST_RADR = 2'd2,
        ST_RACK = 2'd3
    } br_state_e;

    // Request attributes decoded from the Wishbone side
    typedef struct packed {
        logic valid;
        logic write;
        logic hit;
    } req_kind_t;

    function automatic logic acks_in(br_state_e s);
        return (s == ST_WACK) || (s == ST_RACK);
    endfunction

endpackage

// File: rtl/wb2csr_decode.sv
module wb2csr_decode #(
    parameter int ADDR_W = 30,
    parameter int SEG_W = 8,
    parameter int CSR_AW = 22,
    parameter logic [(SEG_W > 0 ? SEG_W : 1)-1:0] SEG_BASE = '1
) (
    input  logic [ADDR_W-1:0] adr,
    output logic              hit,
    output logic [CSR_AW-1:0] reg_adr
);
    localparam int SEG_LSB = ADDR_W - SEG_W;

    assign reg_adr = adr[CSR_AW-1:0];

    generate
        if (SEG_W == 0) begin : g_noseg
            assign hit = 1'b1;
        end else begin : g_seg
            assign hit = (adr[ADDR_W-1:SEG_LSB] == SEG_BASE);
        end
    endgenerate

endmodule

// File: rtl/wb2csr_seq.sv
module wb2csr_seq
    import wb2csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  req_kind_t req,
    output logic      load,
    output logic      rd_sel,
    output logic      ack,
    output logic      we
);
    br_state_e state, state_nx;

    assign load = (state == ST_IDLE) && req.valid && req.hit;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (load) state_nx = req.write ? ST_WACK : ST_RADR;
            ST_WACK: state_nx = ST_IDLE;
            ST_RADR: state_nx = ST_RACK;
            ST_RACK: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign ack    = acks_in(state);
    assign we     = (state == ST_WACK);
    assign rd_sel = (state == ST_RACK);

    // R3
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R2
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

    // R4
    read_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RADR) |=> (ack && !we));

    // R6
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req.valid && !req.hit) |=> (!ack && !we));

endmodule

// File: rtl/wb2csr_datapath.sv
module wb2csr_datapath #(
    parameter int DATA_W = 32,
    parameter int CSR_AW = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              rd_sel,
    input  logic [CSR_AW-1:0] adr_in,
    input  logic [DATA_W-1:0] wdat_in,
    input  logic [DATA_W-1:0] csr_rdat,
    output logic [CSR_AW-1:0] csr_adr,
    output logic [DATA_W-1:0] csr_wdat,
    output logic [DATA_W-1:0] wb_rdat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            csr_adr  <= '0;
            csr_wdat <= '0;
        end else if (load) begin
            csr_adr  <= adr_in;
            csr_wdat <= wdat_in;
        end
    end

    assign wb_rdat = rd_sel ? csr_rdat : '0;

    // R6
    adr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(csr_adr));

endmodule

// File: rtl/wb2csr_bridge.sv
module wb2csr_bridge
    import wb2csr_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int SEG_W = 8,
    parameter int CSR_AW = ADDR_W - SEG_W,
    parameter logic [(SEG_W > 0 ? SEG_W : 1)-1:0] SEG_BASE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_adr,
    input  logic [DATA_W-1:0] wb_dat_w,
    output logic [DATA_W-1:0] wb_dat_r,
    output logic              wb_ack,
    output logic [CSR_AW-1:0] csr_adr,
    output logic              csr_we,
    output logic [DATA_W-1:0] csr_dat_w,
    input  logic [DATA_W-1:0] csr_dat_r
);
    req_kind_t         req;
    logic              hit, load, rd_sel;
    logic [CSR_AW-1:0] dec_adr;

    wb2csr_decode #(
        .ADDR_W(ADDR_W), .SEG_W(SEG_W), .CSR_AW(CSR_AW), .SEG_BASE(SEG_BASE)
    ) u_decode (
        .adr(wb_adr), .hit(hit), .reg_adr(dec_adr)
    );

    assign req.valid = wb_cyc && wb_stb;
    assign req.write = wb_we;
    assign req.hit   = hit;

    wb2csr_seq u_seq (
        .clk(clk), .rst(rst), .req(req), .load(load),
        .rd_sel(rd_sel), .ack(wb_ack), .we(csr_we)
    );

    wb2csr_datapath #(
        .DATA_W(DATA_W), .CSR_AW(CSR_AW)
    ) u_dp (
        .clk(clk), .rst(rst), .load(load), .rd_sel(rd_sel),
        .adr_in(dec_adr), .wdat_in(wb_dat_w), .csr_rdat(csr_dat_r),
        .csr_adr(csr_adr), .csr_wdat(csr_dat_w), .wb_rdat(wb_dat_r)
    );

    // R5
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!wb_ack || csr_we) |-> (wb_dat_r == '0));

endmodule

// File: tb/wb2csr_bridge_tb_top.sv
module wb2csr_bridge_tb_top;
    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam int SEG_W = 8;
    localparam int CSR_AW = 14;
    localparam logic [7:0] SEG_BASE = 8'hE0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [ADDR_W-1:0] wb_adr = '0;
    logic [DATA_W-1:0] wb_dat_w = '0;
    logic [DATA_W-1:0] wb_dat_r;
    logic wb_ack;
    logic [CSR_AW-1:0] csr_adr;
    logic csr_we;
    logic [DATA_W-1:0] csr_dat_w;
    logic [DATA_W-1:0] csr_dat_r;

    int checks = 0;
    int fails = 0;
    logic [DATA_W-1:0] shadow [0:63];

    always #5 clk = ~clk;

    wb2csr_bridge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W),
        .CSR_AW(CSR_AW), .SEG_BASE(SEG_BASE)
    ) dut_i (
        .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
        .wb_ack(wb_ack), .csr_adr(csr_adr), .csr_we(csr_we),
        .csr_dat_w(csr_dat_w), .csr_dat_r(csr_dat_r)
    );

    // Registered register-bank model on the register-bus side
    logic [DATA_W-1:0] bank [0:63];
    always_ff @(posedge clk) begin
        if (csr_we) bank[csr_adr[5:0]] <= csr_dat_w;
        csr_dat_r <= bank[csr_adr[5:0]];
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input logic [7:0] seg,
                                             input logic [7:0] mid,
                                             input logic [13:0] reg_a);
        return {seg, mid, reg_a};
    endfunction

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_dat_w = d;
        @(posedge clk); #1;
        chk(csr_we === 1'b1, "R2 we", 32'(csr_we), 1);
        chk(csr_adr === a[CSR_AW-1:0], "R2 adr", 32'(csr_adr), 32'(a[CSR_AW-1:0]));
        chk(csr_dat_w === d, "R2 data", csr_dat_w, d);
        chk(wb_ack === 1'b1, "R3 write ack", 32'(wb_ack), 1);
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
        @(posedge clk); #1;
        chk(wb_ack === 1'b0 && csr_we === 1'b0, "R3 single ack",
            32'({wb_ack, csr_we}), 0);
        shadow[a[5:0]] = d;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
        @(posedge clk); #1;
        chk(wb_ack === 1'b0 && csr_we === 1'b0, "R4 addr phase",
            32'({wb_ack, csr_we}), 0);
        chk(csr_adr === a[CSR_AW-1:0], "R4 adr", 32'(csr_adr), 32'(a[CSR_AW-1:0]));
        @(posedge clk); #1;
        chk(wb_ack === 1'b1, "R4 read ack", 32'(wb_ack), 1);
        chk(wb_dat_r === exp, "R5 read data", wb_dat_r, exp);
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0;
        @(posedge clk); #1;
        chk(wb_ack === 1'b0 && wb_dat_r === '0, "R5 idle data", wb_dat_r, 0);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(wb_ack === 1'b0 && csr_we === 1'b0, "R1 ctrl", 32'({wb_ack, csr_we}), 0);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        chk(csr_adr === '0 && csr_dat_w === '0 && wb_ack === 1'b0, "R1 regs",
            csr_dat_w, 0);
    endtask

    task automatic t_basic();
        do_write(mk(8'hE0, 8'h00, 14'h0005), 32'hDEAD_BEEF);
        do_write(mk(8'hE0, 8'h00, 14'h0012), 32'h1234_5678);
        do_read(mk(8'hE0, 8'h00, 14'h0005), shadow[5]);
        do_read(mk(8'hE0, 8'h00, 14'h0012), shadow[6'h12]);
        do_write(mk(8'hE0, 8'h00, 14'h0005), 32'h0000_0001);
        do_read(mk(8'hE0, 8'h00, 14'h0005), 32'h0000_0001);
    endtask

    task automatic t_alias();
        // R7: middle bits differ, same register
        do_write(mk(8'hE0, 8'h5A, 14'h0021), 32'hA5A5_0F0F);
        do_read(mk(8'hE0, 8'h00, 14'h0021), 32'hA5A5_0F0F);
        do_read(mk(8'hE0, 8'hFF, 14'h0021), 32'hA5A5_0F0F);
    endtask

    task automatic t_miss();
        logic [CSR_AW-1:0] held;
        held = csr_adr;
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 1;
        wb_adr = mk(8'h12, 8'h00, 14'h0005); wb_dat_w = 32'hFFFF_FFFF;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk(wb_ack === 1'b0 && csr_we === 1'b0, "R6 no claim",
                32'({wb_ack, csr_we}), 0);
        end
        chk(csr_adr === held, "R6 adr kept", 32'(csr_adr), 32'(held));
        @(negedge clk); wb_cyc = 0; wb_stb = 0; wb_we = 0;
        do_read(mk(8'hE0, 8'h00, 14'h0005), 32'h0000_0001);
    endtask

    task automatic t_strobe_only();
        @(negedge clk);
        wb_cyc = 1; wb_stb = 0; wb_we = 1;
        wb_adr = mk(8'hE0, 8'h00, 14'h0012); wb_dat_w = 32'h0BAD_0BAD;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(wb_ack === 1'b0 && csr_we === 1'b0, "R8 cyc only",
                32'({wb_ack, csr_we}), 0);
        end
        @(negedge clk); wb_cyc = 0; wb_stb = 1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(wb_ack === 1'b0 && csr_we === 1'b0, "R8 stb only",
                32'({wb_ack, csr_we}), 0);
        end
        @(negedge clk); wb_stb = 0; wb_we = 0;
        do_read(mk(8'hE0, 8'h00, 14'h0012), 32'h1234_5678);
    endtask

    task automatic t_held_read();
        // R8: request held through the whole read; no second sample before ack ends
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = mk(8'hE0, 8'h00, 14'h0021);
        @(posedge clk); #1;
        chk(wb_ack === 1'b0, "R8 addr phase", 32'(wb_ack), 0);
        @(posedge clk); #1;
        chk(wb_ack === 1'b1 && wb_dat_r === 32'hA5A5_0F0F, "R8 ack data",
            wb_dat_r, 32'hA5A5_0F0F);
        @(posedge clk); #1;
        chk(wb_ack === 1'b0, "R8 gap after ack", 32'(wb_ack), 0);
        @(negedge clk); wb_cyc = 0; wb_stb = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(wb_ack === 1'b0, "R8 quiet", 32'(wb_ack), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_alias();
        t_miss();
        t_strobe_only();
        t_held_read();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule